// File: doc/BRIEF.md
# Operand Fetch and Effective Address Unit

This unit runs the operand phase of a small 8-bit accumulator processor once the opcode has been decoded. It takes a three-bit addressing-mode code, the program counter of the opcode byte and the 8-bit index register. It then reads the operand bytes that follow the opcode, one at a time, over a plain fetch port: an address, a read strobe and a data-valid return. When the last operand byte is taken it reports the instruction length, the address of the next instruction, and one of three results: an immediate data byte, a 16-bit effective address, or a branch target.

The mode, program counter and index are captured on the start pulse, so the decoder may move on at once. A one-cycle done pulse marks the moment the results are valid. They then stay unchanged until the next accepted start. Opcode decoding, arithmetic, data writes, interrupts and the stack belong to other blocks.

Top module: `opfetch_agu`

## Requirements
- R1: Mode codes and instruction lengths: 0 inherent (1), 1 immediate (2), 2 direct (2), 3 extended (3), 4 indexed without offset (1), 5 indexed with 8-bit offset (2), 6 indexed with 16-bit offset (3), 7 relative (2). `len_o` gives the length in bytes.
- R2: From the cycle after an accepted start, `fetch_rd_o` is high for each operand byte, with `fetch_addr_o` = start PC + 1 + k (mod 2^16) for the k-th operand byte. Address and strobe hold until `fetch_valid_i` is seen high, and `fetch_valid_i` has no effect while `fetch_rd_o` is low.
- R3: `done_o` is high for exactly one cycle: the cycle after the last operand byte is accepted, or the cycle after start for one-byte modes. `fetch_rd_o` is low in that cycle, and both are low after reset.
- R4: `next_pc_o` equals the start PC plus `len_o`, modulo 2^16.
- R5: In immediate mode `imm_o` is the first operand byte. In every other mode `imm_o` is 0. Immediate and inherent modes report neither an address nor a target (`ea_valid_o` = `tgt_valid_o` = 0, `ea_o` = `tgt_o` = 0).
- R6: Direct mode gives `ea_o` = {0x00, operand}. Extended mode gives `ea_o` = {first byte, second byte}, the first byte being the high half. `ea_valid_o` is 1 in both modes.
- R7: Indexed modes set `ea_valid_o`. Without offset, `ea_o` = zero-extended index. With an 8-bit offset, `ea_o` = offset + index as a carry-keeping 16-bit sum (at most 0x01FE). With a 16-bit offset (high byte first), `ea_o` = offset + index modulo 2^16.
- R8: Relative mode sets `tgt_valid_o` and gives `tgt_o` = `next_pc_o` + sign-extended operand byte (mod 2^16). `ea_valid_o` is 0.
- R9: A start that arrives while an instruction is in progress, including its done cycle, is ignored. The fetch sequence and the reported results are those of the instruction already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin operand phase; captures mode, PC, index |
| mode_i | input | 3 | Addressing-mode code (R1) |
| pc_i | input | 16 | Address of the opcode byte |
| idx_i | input | 8 | Index register value |
| fetch_addr_o | output | 16 | Program-memory read address |
| fetch_rd_o | output | 1 | Read request |
| fetch_valid_i | input | 1 | Read data valid; accepts the byte |
| fetch_data_i | input | 8 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| len_o | output | 2 | Instruction length in bytes |
| next_pc_o | output | 16 | Address of the next instruction |
| imm_o | output | 8 | Immediate data byte |
| ea_o | output | 16 | Effective operand address |
| ea_valid_o | output | 1 | `ea_o` holds an address |
| tgt_o | output | 16 | Branch target |
| tgt_valid_o | output | 1 | `tgt_o` holds a target |

## Verification
The bound assertions check the handshake on every cycle: the fetch address and strobe stay put while the port stalls, and the address steps by one between operand bytes. Done never overlaps a read and lasts a single cycle. A reported branch target always comes with length two and no effective address. The arithmetic of each mode, the wrap of addresses at the top of memory, the sign extension of branch offsets and the rejection of late start pulses can only be shown by the bench. It sweeps every mode over a grid of program counters, index values, operand bytes and stall lengths, and compares against values it computes itself.

// File: rtl/opf_pkg.sv
package opf_pkg;

    typedef enum logic [2:0] {
        AM_INH = 3'd0,
        AM_IMM = 3'd1,
        AM_DIR = 3'd2,
        AM_EXT = 3'd3,
        AM_IX0 = 3'd4,
        AM_IX1 = 3'd5,
        AM_IX2 = 3'd6,
        AM_REL = 3'd7
    } amode_e;

    // most operand bytes any mode carries after the opcode
    localparam int MAX_OPND = 2;
    localparam int CNT_W    = $clog2(MAX_OPND + 1);
    localparam int SLOT_W   = (MAX_OPND > 1) ? $clog2(MAX_OPND) : 1;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_DONE  = 2'd2
    } sq_e;

    function automatic logic [CNT_W-1:0] opnd_count(amode_e m);
        logic [CNT_W-1:0] n;
        case (m)
            AM_INH, AM_IX0: n = CNT_W'(0);
            AM_EXT, AM_IX2: n = CNT_W'(2);
            default:        n = CNT_W'(1);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/opf_seq.sv
module opf_seq
    import opf_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic [2:0]                        mode_i,
    input  logic [ADDR_W-1:0]                 pc_i,
    input  logic [DATA_W-1:0]                 idx_i,
    input  logic                              fetch_valid_i,
    input  logic [DATA_W-1:0]                 fetch_data_i,
    output logic [ADDR_W-1:0]                 fetch_addr_o,
    output logic                              fetch_rd_o,
    output logic                              done_o,
    output amode_e                            mode_o,
    output logic [ADDR_W-1:0]                 pc_o,
    output logic [DATA_W-1:0]                 idx_o,
    output logic [MAX_OPND-1:0][DATA_W-1:0]   opnd_o
);

    typedef struct packed {
        sq_e                              st;
        logic [CNT_W-1:0]                 cnt;
        logic [CNT_W-1:0]                 need;
        amode_e                           mode;
        logic [ADDR_W-1:0]                pc;
        logic [DATA_W-1:0]                idx;
        logic [MAX_OPND-1:0][DATA_W-1:0]  opnd;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        amode_e           m_in;
        logic [CNT_W-1:0] n_in;
        m_in  = amode_e'(mode_i);
        n_in  = opnd_count(m_in);
        seq_d = seq_q;
        case (seq_q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    seq_d.mode = m_in;
                    seq_d.pc   = pc_i;
                    seq_d.idx  = idx_i;
                    seq_d.cnt  = '0;
                    seq_d.need = n_in;
                    seq_d.opnd = '0;
                    seq_d.st   = (n_in == '0) ? SQ_DONE : SQ_FETCH;
                end
            end
            SQ_FETCH: begin
                if (fetch_valid_i) begin
                    seq_d.opnd[seq_q.cnt[SLOT_W-1:0]] = fetch_data_i;
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                    if (seq_q.cnt + CNT_W'(1) == seq_q.need) begin
                        seq_d.st = SQ_DONE;
                    end
                end
            end
            SQ_DONE: begin
                seq_d.st = SQ_IDLE;
            end
            default: begin
                seq_d.st = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign fetch_rd_o   = (seq_q.st == SQ_FETCH);
    assign fetch_addr_o = seq_q.pc + ADDR_W'(seq_q.cnt) + ADDR_W'(1);
    assign done_o       = (seq_q.st == SQ_DONE);
    assign mode_o       = seq_q.mode;
    assign pc_o         = seq_q.pc;
    assign idx_o        = seq_q.idx;
    assign opnd_o       = seq_q.opnd;

endmodule

// File: rtl/opf_agu.sv
module opf_agu
    import opf_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  amode_e                            mode_i,
    input  logic [ADDR_W-1:0]                 pc_i,
    input  logic [DATA_W-1:0]                 idx_i,
    input  logic [MAX_OPND-1:0][DATA_W-1:0]   opnd_i,
    output logic [1:0]                        len_o,
    output logic [ADDR_W-1:0]                 next_pc_o,
    output logic [DATA_W-1:0]                 imm_o,
    output logic [ADDR_W-1:0]                 ea_o,
    output logic                              ea_valid_o,
    output logic [ADDR_W-1:0]                 tgt_o,
    output logic                              tgt_valid_o
);

    logic [DATA_W-1:0] hi_b, lo_b;
    logic [ADDR_W-1:0] idx_z, off8_z, off8_s, off16;

    assign hi_b   = opnd_i[0];
    assign lo_b   = opnd_i[1];
    assign idx_z  = {{DATA_W{1'b0}}, idx_i};
    assign off8_z = {{DATA_W{1'b0}}, hi_b};
    assign off8_s = {{DATA_W{hi_b[DATA_W-1]}}, hi_b};
    assign off16  = {hi_b, lo_b};

    assign len_o     = 2'(opnd_count(mode_i)) + 2'd1;
    assign next_pc_o = pc_i + ADDR_W'(len_o);

    always_comb begin
        imm_o       = '0;
        ea_o        = '0;
        ea_valid_o  = 1'b0;
        tgt_o       = '0;
        tgt_valid_o = 1'b0;
        case (mode_i)
            AM_IMM: imm_o = hi_b;
            AM_DIR: begin
                ea_o       = off8_z;
                ea_valid_o = 1'b1;
            end
            AM_EXT: begin
                ea_o       = off16;
                ea_valid_o = 1'b1;
            end
            AM_IX0: begin
                ea_o       = idx_z;
                ea_valid_o = 1'b1;
            end
            AM_IX1: begin
                ea_o       = off8_z + idx_z;
                ea_valid_o = 1'b1;
            end
            AM_IX2: begin
                ea_o       = off16 + idx_z;
                ea_valid_o = 1'b1;
            end
            AM_REL: begin
                tgt_o       = next_pc_o + off8_s;
                tgt_valid_o = 1'b1;
            end
            default: begin
                imm_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/opfetch_agu.sv
module opfetch_agu
    import opf_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        mode_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] idx_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              fetch_rd_o,
    input  logic              fetch_valid_i,
    input  logic [DATA_W-1:0] fetch_data_i,
    output logic              done_o,
    output logic [1:0]        len_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic [DATA_W-1:0] imm_o,
    output logic [ADDR_W-1:0] ea_o,
    output logic              ea_valid_o,
    output logic [ADDR_W-1:0] tgt_o,
    output logic              tgt_valid_o
);

    amode_e                           cap_mode;
    logic [ADDR_W-1:0]                cap_pc;
    logic [DATA_W-1:0]                cap_idx;
    logic [MAX_OPND-1:0][DATA_W-1:0]  cap_opnd;

    opf_seq #(.DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mode_i       (mode_i),
        .pc_i         (pc_i),
        .idx_i        (idx_i),
        .fetch_valid_i(fetch_valid_i),
        .fetch_data_i (fetch_data_i),
        .fetch_addr_o (fetch_addr_o),
        .fetch_rd_o   (fetch_rd_o),
        .done_o       (done_o),
        .mode_o       (cap_mode),
        .pc_o         (cap_pc),
        .idx_o        (cap_idx),
        .opnd_o       (cap_opnd)
    );

    opf_agu #(.DATA_W(DATA_W)) u_agu (
        .mode_i      (cap_mode),
        .pc_i        (cap_pc),
        .idx_i       (cap_idx),
        .opnd_i      (cap_opnd),
        .len_o       (len_o),
        .next_pc_o   (next_pc_o),
        .imm_o       (imm_o),
        .ea_o        (ea_o),
        .ea_valid_o  (ea_valid_o),
        .tgt_o       (tgt_o),
        .tgt_valid_o (tgt_valid_o)
    );

endmodule

// File: rtl/opf_chk.sv
module opf_chk #(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic              fetch_rd_o,
    input logic              fetch_valid_i,
    input logic              done_o,
    input logic [1:0]        len_o,
    input logic              ea_valid_o,
    input logic              tgt_valid_o
);

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rd_o && !fetch_valid_i |=> fetch_rd_o && $stable(fetch_addr_o));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rd_o && fetch_valid_i |=>
            (!fetch_rd_o || fetch_addr_o == ADDR_W'($past(fetch_addr_o) + 1'b1)));

    // R3
    done_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !fetch_rd_o);

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> len_o != 2'd0);

    // R8
    branch_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && tgt_valid_o |-> len_o == 2'd2 && !ea_valid_o);

endmodule

bind opfetch_agu opf_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_addr_o (fetch_addr_o),
    .fetch_rd_o   (fetch_rd_o),
    .fetch_valid_i(fetch_valid_i),
    .done_o       (done_o),
    .len_o        (len_o),
    .ea_valid_o   (ea_valid_o),
    .tgt_valid_o  (tgt_valid_o)
);

// File: tb/opfetch_agu_test.sv
module opfetch_agu_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [2:0]  mode_i;
    logic [15:0] pc_i;
    logic [7:0]  idx_i;
    logic [15:0] fetch_addr_o;
    logic        fetch_rd_o;
    logic        fetch_valid_i;
    logic [7:0]  fetch_data_i;
    logic        done_o;
    logic [1:0]  len_o;
    logic [15:0] next_pc_o;
    logic [7:0]  imm_o;
    logic [15:0] ea_o;
    logic        ea_valid_o;
    logic [15:0] tgt_o;
    logic        tgt_valid_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    opfetch_agu uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .pc_i(pc_i), .idx_i(idx_i), .fetch_addr_o(fetch_addr_o),
        .fetch_rd_o(fetch_rd_o), .fetch_valid_i(fetch_valid_i),
        .fetch_data_i(fetch_data_i), .done_o(done_o), .len_o(len_o),
        .next_pc_o(next_pc_o), .imm_o(imm_o), .ea_o(ea_o),
        .ea_valid_o(ea_valid_o), .tgt_o(tgt_o), .tgt_valid_o(tgt_valid_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_len(input logic [2:0] m);
        case (m)
            3'd0, 3'd4: return 2'd1;
            3'd3, 3'd6: return 2'd3;
            default:    return 2'd2;
        endcase
    endfunction

    task automatic run(input logic [2:0] m, input logic [15:0] pc,
                       input logic [7:0] ix, input logic [7:0] b0,
                       input logic [7:0] b1, input int lat, input bit poke);
        logic [1:0]  len;
        logic [15:0] npc, ea, tgt, addr;
        logic [7:0]  imm;
        bit          eav, tgv;
        len = exp_len(m);
        npc = pc + 16'(len);
        imm = (m == 3'd1) ? b0 : 8'h00;
        eav = (m >= 3'd2 && m <= 3'd6);
        tgv = (m == 3'd7);
        case (m)
            3'd2:    ea = {8'h00, b0};
            3'd3:    ea = {b0, b1};
            3'd4:    ea = {8'h00, ix};
            3'd5:    ea = 16'(b0) + 16'(ix);
            3'd6:    ea = {b0, b1} + 16'(ix);
            default: ea = 16'h0000;
        endcase
        tgt = tgv ? npc + {{8{b0[7]}}, b0} : 16'h0000;

        start_i = 1'b1; mode_i = m; pc_i = pc; idx_i = ix;
        @(negedge clk);
        start_i = 1'b0; mode_i = ~m; pc_i = ~pc; idx_i = ~ix;
        for (int k = 0; k < int'(len) - 1; k++) begin
            addr = pc + 16'(k) + 16'd1;
            check(fetch_rd_o == 1'b1, "R2", "read strobe", 32'(fetch_rd_o), 32'd1);
            check(fetch_addr_o == addr, "R2", "fetch address", 32'(fetch_addr_o), 32'(addr));
            for (int l = 0; l < lat; l++) begin
                fetch_valid_i = 1'b0;
                if (poke) begin
                    start_i = 1'b1; mode_i = m ^ 3'd5; pc_i = pc ^ 16'h1234;
                end
                @(negedge clk);
                start_i = 1'b0;
                check(fetch_rd_o && fetch_addr_o == addr, "R2", "stall hold",
                      32'(fetch_addr_o), 32'(addr));
                check(done_o == 1'b0, "R3", "done during stall", 32'(done_o), 32'd0);
            end
            fetch_valid_i = 1'b1;
            fetch_data_i  = (k == 0) ? b0 : b1;
            @(negedge clk);
            fetch_valid_i = 1'b0;
            fetch_data_i  = 8'hEE;
        end
        check(done_o == 1'b1 && fetch_rd_o == 1'b0, "R3", "done pulse",
              {fetch_rd_o, done_o}, 32'd1);
        check(len_o == len, "R1", "length", 32'(len_o), 32'(len));
        check(next_pc_o == npc, "R4", "next pc", 32'(next_pc_o), 32'(npc));
        check(imm_o == imm, "R5", "immediate", 32'(imm_o), 32'(imm));
        check(ea_valid_o == eav && tgt_valid_o == tgv, "R5", "valid flags",
              {ea_valid_o, tgt_valid_o}, {eav, tgv});
        if (m == 3'd2 || m == 3'd3)
            check(ea_o == ea, "R6", "direct/extended address", 32'(ea_o), 32'(ea));
        else if (m >= 3'd4 && m <= 3'd6)
            check(ea_o == ea, "R7", "indexed address", 32'(ea_o), 32'(ea));
        else
            check(ea_o == 16'h0000, "R5", "no address", 32'(ea_o), 32'd0);
        check(tgt_o == tgt, "R8", "branch target", 32'(tgt_o), 32'(tgt));

        // start during the done cycle must be dropped
        if (poke) begin
            start_i = 1'b1; mode_i = 3'd3; pc_i = 16'h4000;
        end
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b0 && fetch_rd_o == 1'b0, "R9", "late start ignored",
              {fetch_rd_o, done_o}, 32'd0);
        check(next_pc_o == npc && ea_o == ea, "R9", "results held",
              32'(next_pc_o), 32'(npc));

        // data-valid while idle has no effect
        fetch_valid_i = 1'b1; fetch_data_i = 8'h99;
        @(negedge clk);
        fetch_valid_i = 1'b0;
        check(done_o == 1'b0 && fetch_rd_o == 1'b0 && imm_o == imm, "R2",
              "idle valid ignored", {fetch_rd_o, done_o}, 32'd0);
    endtask

    initial begin
        logic [15:0] pcs [3];
        logic [7:0]  ixs [3];
        logic [15:0] bys [4];
        int          it;
        pcs[0] = 16'h0100; pcs[1] = 16'hFFFE; pcs[2] = 16'h7FF0;
        ixs[0] = 8'h00;    ixs[1] = 8'hFF;    ixs[2] = 8'h37;
        bys[0] = 16'h80FF; bys[1] = 16'h7F01; bys[2] = 16'h0000; bys[3] = 16'hC35A;
        rst_n = 1'b0; start_i = 1'b0; mode_i = '0; pc_i = '0; idx_i = '0;
        fetch_valid_i = 1'b0; fetch_data_i = '0;
        repeat (3) @(negedge clk);
        check(fetch_rd_o == 1'b0, "R3", "reset read strobe", 32'(fetch_rd_o), 32'd0);
        check(done_o == 1'b0, "R3", "reset done", 32'(done_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        it = 0;
        for (int m = 0; m < 8; m++)
            for (int p = 0; p < 3; p++)
                for (int x = 0; x < 3; x++)
                    for (int b = 0; b < 4; b++) begin
                        run(3'(m), pcs[p], ixs[x], bys[b][15:8], bys[b][7:0],
                            it % 3, it[0]);
                        it++;
                    end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule